// File: doc/BRIEF.md
# Transfer Bit Counter with Selectable Clock Source

This block counts clock events for a serial shift register that sits beside it, so that software learns when a transfer is complete. A small control field picks what drives the count. The count can follow a software strobe, a periodic timer pulse, or both edges of an external serial clock. A further setting makes it follow only the writes that toggle the clock port bit. With an external clock, both edges count, so sixteen counts equal eight data bits. When the count wraps from its top value back to zero, the block sets a sticky overflow flag and emits a one-cycle overflow event. The overflow flag ANDed with its enable forms the interrupt request.

The block also owns the clock port bit. Every write that carries a one in the toggle position inverts that bit, so a master can make a serial clock purely from register writes. In the toggle-count setting, these same writes advance the counter. This lets a master see that a transfer has finished on the last toggle, without waiting for the external edge. The count is loaded directly through its own write port. The block has no streaming data path, so every pin is a plain control or status signal and no back-pressure applies.

Control field layout (`ctl_wdata_i` / `ctl_rdata_o`): bits [3:2] select the source, bit 1 is the strobe / strobe-select bit, and bit 0 is the toggle bit. The source codes are 00 for software strobe, 01 for timer pulse, 10 for external clock (shift on rising edge), and 11 for external clock (shift on falling edge).

Top module: `xbc_top`

## Requirements
- R1: After reset, the count, the overflow flag, the overflow event, the interrupt request, the clock port bit and the control readback are all zero.
- R2: A control write with source 00 and bit 1 set increments the count by one at the next clock edge. A control write with bit 1 clear does not change the count.
- R3: When the registered source is 01, each cycle with `tick_i` high increments the count by one. In every other source setting, `tick_i` has no effect on the count.
- R4: When the registered source is 1x and the registered strobe-select bit is 0, every rising and every falling edge of `ext_clk_i` increments the count by one. The count changes at the clock edge that first samples the new level.
- R5: When the registered source is 1x and the registered strobe-select bit is 1, `ext_clk_i` edges are ignored. Each control write with bit 3 set, bit 1 set and bit 0 set increments the count by one.
- R6: Every control write with bit 0 set inverts `clk_port_o` at the next edge, whatever the source setting. Writes with bit 0 clear leave it unchanged.
- R7: `ctl_rdata_o` returns the last written source in bits [3:2]. Bits 1 and 0 always read as zero.
- R8: An increment from count 15 produces count 0, sets `ovf_flag_o` and raises `ovf_evt_o` for exactly one cycle. These three changes appear at the same edge.
- R9: `ovf_flag_o` stays set until a cycle with `flag_clr_i` high, and further wraps do not clear it. `ovf_irq_o` is high exactly when the flag and `ovf_ie_i` are both high.
- R10: A count write loads `cnt_wdata_i` at the next edge. It takes priority over an increment in the same cycle and never sets the overflow flag or the event.
- R11: Outside count writes, the count changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_i | input | 1 | External serial clock level, synchronous to clk |
| tick_i | input | 1 | One-cycle timer overflow pulse |
| ctl_wr_i | input | 1 | Control field write strobe |
| ctl_wdata_i | input | 4 | Control field write data |
| ctl_rdata_o | output | 4 | Control field readback |
| cnt_wr_i | input | 1 | Count load strobe |
| cnt_wdata_i | input | CNT_W | Count load value |
| cnt_o | output | CNT_W | Current count |
| flag_clr_i | input | 1 | Clear the overflow flag |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_evt_o | output | 1 | One-cycle pulse on each wrap |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| clk_port_o | output | 1 | Clock port bit driven by toggle writes |

## Verification
On every cycle, the assertions check three things: that a count load lands exactly, that the count otherwise moves by at most one step, and that the flag only rises together with an overflow event at count zero. They also check that the flag holds until cleared and that every toggle write inverts the port bit. Only the directed scenarios can show which source is actually selected. That covers software strobe, timer pulse, both external edges, and toggle-counting with external edges ignored. The scenarios also show the readback zeros, the load-over-increment priority, and the interrupt gating.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  localparam int CTL_W = 4;

  typedef enum logic [1:0] {
    SRC_SW    = 2'b00,
    SRC_TMR   = 2'b01,
    SRC_EXT_P = 2'b10,
    SRC_EXT_N = 2'b11
  } src_e;

  localparam int BIT_TGL = 0;
  localparam int BIT_STB = 1;
  localparam int BIT_SRC = 2;
endpackage

// File: rtl/xbc_ctl.sv
module xbc_ctl
  import xbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output src_e             src_o,
  output logic             csel_o,
  output logic             sw_stb_o,
  output logic             tgl_cnt_o,
  output logic             port_o,
  output logic [CTL_W-1:0] rdata_o
);
  src_e src_q;
  logic csel_q;
  logic port_q;
  logic [1:0] wsrc;

  assign wsrc = wdata_i[BIT_SRC+1:BIT_SRC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= SRC_SW;
      csel_q <= 1'b0;
      port_q <= 1'b0;
    end else if (wr_i) begin
      src_q  <= src_e'(wsrc);
      csel_q <= wdata_i[BIT_STB];
      if (wdata_i[BIT_TGL]) port_q <= ~port_q;
    end
  end

  // strobe acts with the source written in the same access
  assign sw_stb_o  = wr_i && wdata_i[BIT_STB] && (wsrc == SRC_SW);
  assign tgl_cnt_o = wr_i && wdata_i[BIT_TGL] && wsrc[1] && wdata_i[BIT_STB];

  assign src_o   = src_q;
  assign csel_o  = csel_q;
  assign port_o  = port_q;
  assign rdata_o = {src_q, 2'b00};
endmodule

// File: rtl/xbc_edge.sv
module xbc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic any_edge_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign any_edge_o = lvl_i ^ lvl_q;
endmodule

// File: rtl/xbc_count.sv
module xbc_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             evt_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic flag_q, evt_q, wrap;

  assign wrap = inc_i && !ld_i && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      if (ld_i)       cnt_q <= ld_val_i;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
      evt_q <= wrap;
      if (wrap)       flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign evt_o  = evt_q;
endmodule

// File: rtl/xbc_top.sv
module xbc_top
  import xbc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_i,
  input  logic             tick_i,
  input  logic             ctl_wr_i,
  input  logic [3:0]       ctl_wdata_i,
  output logic [3:0]       ctl_rdata_o,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  input  logic             flag_clr_i,
  input  logic             ovf_ie_i,
  output logic             ovf_flag_o,
  output logic             ovf_evt_o,
  output logic             ovf_irq_o,
  output logic             clk_port_o
);
  src_e src;
  logic csel, sw_stb, tgl_cnt, ext_edge, inc;

  xbc_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr_i), .wdata_i(ctl_wdata_i),
    .src_o(src), .csel_o(csel), .sw_stb_o(sw_stb), .tgl_cnt_o(tgl_cnt),
    .port_o(clk_port_o), .rdata_o(ctl_rdata_o)
  );

  xbc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(ext_clk_i), .any_edge_o(ext_edge)
  );

  // event mux: one increment per cycle at most
  always_comb begin
    inc = sw_stb || tgl_cnt;
    unique case (src)
      SRC_TMR:              inc = inc || tick_i;
      SRC_EXT_P, SRC_EXT_N: inc = inc || (ext_edge && !csel);
      default:              ;
    endcase
  end

  xbc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .ld_i(cnt_wr_i),
    .ld_val_i(cnt_wdata_i), .clr_i(flag_clr_i),
    .cnt_o(cnt_o), .flag_o(ovf_flag_o), .evt_o(ovf_evt_o)
  );

  assign ovf_irq_o = ovf_flag_o && ovf_ie_i;
endmodule

// File: rtl/xbc_checker.sv
module xbc_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr_i,
  input logic [3:0]       ctl_wdata_i,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             flag_clr_i,
  input logic             ovf_flag_o,
  input logic             ovf_evt_o,
  input logic             clk_port_o
);
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> cnt_o == $past(cnt_wdata_i));

  assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  assert_evt_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_o |-> (cnt_o == '0) && ovf_flag_o);

  assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag_o) |-> ovf_evt_o);

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag_o && !flag_clr_i |=> ovf_flag_o);

  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_i && ctl_wdata_i[0] |=> clk_port_o != $past(clk_port_o));
endmodule

bind xbc_top xbc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
  .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i), .cnt_o(cnt_o),
  .flag_clr_i(flag_clr_i), .ovf_flag_o(ovf_flag_o), .ovf_evt_o(ovf_evt_o),
  .clk_port_o(clk_port_o)
);

// File: tb/sim_xbc_top.sv
`timescale 1ns/1ps
module sim_xbc_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk = 1'b0, tick = 1'b0, ctl_wr = 1'b0, cnt_wr = 1'b0;
  logic flag_clr = 1'b0, ovf_ie = 1'b0;
  logic [3:0] ctl_wdata = '0, cnt_wdata = '0;
  logic [3:0] ctl_rdata, cnt;
  logic ovf_flag, ovf_evt, ovf_irq, clk_port;
  int errors = 0, checks = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  xbc_top u0 (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .tick_i(tick),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata), .cnt_o(cnt),
    .flag_clr_i(flag_clr), .ovf_ie_i(ovf_ie), .ovf_flag_o(ovf_flag),
    .ovf_evt_o(ovf_evt), .ovf_irq_o(ovf_irq), .clk_port_o(clk_port)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_ctl(input logic [3:0] d);
    ctl_wr = 1'b1; ctl_wdata = d; step(); ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic ld_cnt(input logic [3:0] d);
    cnt_wr = 1'b1; cnt_wdata = d; step(); cnt_wr = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  task automatic flip_ext();
    ext_clk = ~ext_clk; step();
  endtask

  task automatic t_reset();
    chk("R1 count", 8'(cnt), 8'h0);
    chk("R1 flag", 8'(ovf_flag), 8'h0);
    chk("R1 evt", 8'(ovf_evt), 8'h0);
    chk("R1 irq", 8'(ovf_irq), 8'h0);
    chk("R1 port", 8'(clk_port), 8'h0);
    chk("R1 rdata", 8'(ctl_rdata), 8'h0);
  endtask

  task automatic t_sw();
    wr_ctl(4'b0010);
    chk("R2 strobe 1", 8'(cnt), 8'h1);
    wr_ctl(4'b0010);
    chk("R2 strobe 2", 8'(cnt), 8'h2);
    wr_ctl(4'b0000);
    chk("R2 no strobe", 8'(cnt), 8'h2);
    chk("R7 strobe reads zero", 8'(ctl_rdata), 8'h0);
  endtask

  task automatic t_timer();
    pulse_tick();
    chk("R3 tick ignored src00", 8'(cnt), 8'h2);
    wr_ctl(4'b0100);
    chk("R3 select no inc", 8'(cnt), 8'h2);
    for (int i = 0; i < 3; i++) pulse_tick();
    chk("R3 three ticks", 8'(cnt), 8'h5);
    chk("R7 rdata timer", 8'(ctl_rdata), 8'h4);
  endtask

  task automatic t_ext();
    ld_cnt(4'h0);
    wr_ctl(4'b1000);
    for (int i = 0; i < 4; i++) flip_ext();
    chk("R4 both edges", 8'(cnt), 8'h4);
    pulse_tick();
    chk("R3 tick ignored ext", 8'(cnt), 8'h4);
    wr_ctl(4'b1101);
    chk("R6 toggle in ext mode", 8'(clk_port), 8'h1);
    chk("R4 toggle no count csel0", 8'(cnt), 8'h4);
    flip_ext();
    chk("R4 falling-shift source", 8'(cnt), 8'h5);
  endtask

  task automatic t_tgl();
    wr_ctl(4'b1011);
    chk("R5 toggle counts", 8'(cnt), 8'h6);
    chk("R6 port back", 8'(clk_port), 8'h0);
    chk("R7 rdata bits low", 8'(ctl_rdata), 8'h8);
    flip_ext(); flip_ext();
    chk("R5 ext edges ignored", 8'(cnt), 8'h6);
    wr_ctl(4'b1011);
    chk("R5 toggle counts again", 8'(cnt), 8'h7);
    chk("R6 port toggled", 8'(clk_port), 8'h1);
    wr_ctl(4'b0000);
    chk("R6 no toggle bit", 8'(clk_port), 8'h1);
  endtask

  task automatic t_wrap();
    ld_cnt(4'hE);
    wr_ctl(4'b0010);
    chk("R8 at 15", 8'(cnt), 8'hF);
    chk("R8 no evt at 15", 8'(ovf_evt), 8'h0);
    wr_ctl(4'b0010);
    chk("R8 wrap count", 8'(cnt), 8'h0);
    chk("R8 flag set", 8'(ovf_flag), 8'h1);
    chk("R8 evt set", 8'(ovf_evt), 8'h1);
    chk("R9 irq masked", 8'(ovf_irq), 8'h0);
    step();
    chk("R8 evt one cycle", 8'(ovf_evt), 8'h0);
    chk("R9 flag sticky", 8'(ovf_flag), 8'h1);
    ovf_ie = 1'b1; #1;
    chk("R9 irq enabled", 8'(ovf_irq), 8'h1);
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    chk("R9 flag cleared", 8'(ovf_flag), 8'h0);
    chk("R9 irq cleared", 8'(ovf_irq), 8'h0);
    ovf_ie = 1'b0;
  endtask

  task automatic t_prio();
    ld_cnt(4'hF);
    cnt_wr = 1'b1; cnt_wdata = 4'h3; ctl_wr = 1'b1; ctl_wdata = 4'b0010;
    step();
    cnt_wr = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0;
    chk("R10 load beats inc", 8'(cnt), 8'h3);
    chk("R10 no flag", 8'(ovf_flag), 8'h0);
    ld_cnt(4'hF);
    ld_cnt(4'h0);
    chk("R10 load 15->0", 8'(cnt), 8'h0);
    chk("R10 no evt", 8'(ovf_evt), 8'h0);
    chk("R10 no flag on load", 8'(ovf_flag), 8'h0);
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_sw();
    t_timer();
    t_ext();
    t_tgl();
    t_wrap();
    t_prio();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule